// File: doc/BRIEF.md
# Dual-Lane Signed Multiply-Accumulate Pipeline

This block is the multiply pipe of a small vector unit. Each accepted instruction multiplies two signed 32-bit elements per lane, for two lanes, into two 64-bit products. A multiply-accumulate also adds the 128-bit value already held in the destination. The pipe is eight stages deep and takes at most one instruction every two cycles. The register file sits outside the block. The accumulator is fetched through a read port in stage 3. Results leave through a result port in stage 8, and the surrounding logic writes them back on that clock edge.

A multiply-accumulate may target the same destination as the instruction accepted two cycles earlier. In that case the pipe does not wait for the write-back. It takes the older result straight from stage 8 while the newer instruction sits in stage 6. A chain of dependent accumulates therefore issues at full rate. Any other accumulate whose destination is still in flight is held off at issue until its read in stage 3 is safe. The surrounding logic is expected to release reset synchronously.

Top module: `mac2_pipe`

## Requirements
- R1: For each lane l (l = 0, 1), the result bits [64l+63:64l] equal the signed product of issue_a[32l+31:32l] and issue_b[32l+31:32l], plus the accumulator for an accumulate. Opcode 0 is plain multiply and opcode 1 is multiply-accumulate.
- R2: In the cycle after an instruction is accepted (issue_valid and issue_ready high at a clock edge), issue_ready is low.
- R3: res_valid is high in exactly one cycle, 8 clock edges after the accepting edge. In that cycle res_dst carries the instruction's destination and res_data carries its result.
- R4: An accumulate that is not chained raises acc_rd_en, with acc_rd_dst equal to its destination, 3 edges after acceptance. It adds the acc_rd_data value sampled in that cycle.
- R5: An accumulate accepted exactly two edges after an instruction with the same destination is accepted without a stall and never raises acc_rd_en. It adds that instruction's result, taken internally.
- R6: A multiply, then an accumulate, then another accumulate, all to one destination and accepted at the minimum spacing, produce the final result 12 edges after the first acceptance.
- R7: issue_ready is low while the offered instruction is an accumulate that is not chained and an instruction with the same destination was accepted 1 to 5 edges earlier.
- R8: Accumulation wraps modulo 2^64 in each lane, with no indication of overflow.
- R9: While reset is asserted and after it is released, res_valid and acc_rd_en are low, and issue_ready is high when nothing is in stage 1.
- R10: A plain multiply never raises acc_rd_en, and its result does not depend on acc_rd_data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Instruction offered |
| issue_ready | output | 1 | Instruction can be accepted this cycle |
| issue_op | input | 1 | 0 multiply, 1 multiply-accumulate |
| issue_dst | input | DST_W | Destination register index |
| issue_a | input | LANES*EW | Operand a, lane l at bits [EW*l+EW-1:EW*l] |
| issue_b | input | LANES*EW | Operand b, same layout |
| acc_rd_en | output | 1 | Accumulator read request (stage 3) |
| acc_rd_dst | output | DST_W | Register index to read |
| acc_rd_data | input | LANES*2*EW | Read data, returned in the same cycle |
| res_valid | output | 1 | Result present (stage 8) |
| res_dst | output | DST_W | Destination of the result |
| res_data | output | LANES*2*EW | Result, lane l at bits [2EW*l+2EW-1:2EW*l] |

## Verification
The bench runs accumulate chains at the minimum spacing. A design that read the accumulator in stage 3 for these chains would pick up a stale register value and give a wrong sum. A design that did not recognise the chain would stall it and deliver the final result after edge 12. The bench also places an accumulate behind an unrelated instruction that sits between it and its producer. A design that applied forwarding too widely, or stalled too briefly, would either read the port while the producer is still in flight or lose the producer's result. Extreme operands are included: the most negative value times itself, and repeated accumulation across the 2^63 boundary. Sign-extension errors and carries that spill across lanes show up directly in these results.

// File: rtl/mac2_pkg.sv
package mac2_pkg;
  // Stage positions; the forwarding and hazard windows depend on them.
  localparam int STAGES       = 8;  // result leaves in this stage
  localparam int MUL_STAGE    = 3;  // product registered entering this stage
  localparam int ACC_RD_STAGE = 3;  // normal accumulator read
  localparam int FWD_STAGE    = 6;  // late accumulator pick-up for chains
  // Stage in which the producer of a chained accumulate sits when that
  // accumulate is offered: the chain consumer then meets it at STAGES.
  localparam int CHAIN_STAGE  = STAGES - FWD_STAGE;
  // Instructions in stages 1..HAZ_LAST are not yet written back when an
  // accumulate offered now reaches ACC_RD_STAGE.
  localparam int HAZ_LAST     = STAGES - ACC_RD_STAGE;

  typedef enum logic {
    OP_MUL = 1'b0,
    OP_MAC = 1'b1
  } mac2_op_e;
endpackage

// File: rtl/mac2_issue_ctl.sv
module mac2_issue_ctl
  import mac2_pkg::*;
#(
  parameter int DST_W = 4
) (
  input  logic                             issue_valid,
  input  logic                             issue_op,
  input  logic [DST_W-1:0]                 issue_dst,
  input  logic [HAZ_LAST:1]                stg_vld,
  input  logic [HAZ_LAST:1][DST_W-1:0]     stg_dst,
  output logic                             issue_ready,
  output logic                             take,
  output logic                             take_chain
);
  logic is_mac;
  logic chain;
  logic conflict;

  always_comb begin
    is_mac   = (issue_op == OP_MAC);
    chain    = is_mac && stg_vld[CHAIN_STAGE] &&
               (stg_dst[CHAIN_STAGE] == issue_dst);
    conflict = 1'b0;
    for (int k = 1; k <= HAZ_LAST; k++) begin
      if (stg_vld[k] && (stg_dst[k] == issue_dst)) conflict = 1'b1;
    end
    // Stage 1 busy enforces the two-cycle issue slot; with stage 1 empty,
    // the stage-2 occupant is the youngest instruction in flight.
    issue_ready = !stg_vld[1] && !(is_mac && conflict && !chain);
    take        = issue_valid && issue_ready;
    take_chain  = take && chain;
  end
endmodule

// File: rtl/mac2_lane.sv
module mac2_lane
  import mac2_pkg::*;
#(
  parameter int EW = 32
) (
  input  logic                 clk,
  input  logic                 take,
  input  logic [STAGES-1:1]    vld,
  input  logic [EW-1:0]        op_a,
  input  logic [EW-1:0]        op_b,
  input  logic                 acc_take,
  input  logic [2*EW-1:0]      acc_in,
  input  logic                 fwd_take,
  output logic [2*EW-1:0]      sum_out
);
  localparam int PW = 2 * EW;

  logic [EW-1:0] a_q [1:2];
  logic [EW-1:0] b_q [1:2];
  logic [PW-1:0] prod_q [MUL_STAGE:FWD_STAGE];
  logic [PW-1:0] acc_q  [ACC_RD_STAGE+1:FWD_STAGE];
  logic [PW-1:0] sum_q  [FWD_STAGE+1:STAGES];

  logic [PW-1:0] prod_d;
  logic [PW-1:0] acc_d;
  logic [PW-1:0] sum_d;

  // next-state
  always_comb begin
    prod_d = {{EW{a_q[2][EW-1]}}, a_q[2]} * {{EW{b_q[2][EW-1]}}, b_q[2]};
    acc_d  = acc_take ? acc_in : '0;
    sum_d  = prod_q[FWD_STAGE] + (fwd_take ? sum_q[STAGES] : acc_q[FWD_STAGE]);
  end

  // operand staging
  always_ff @(posedge clk) begin
    if (take) begin
      a_q[1] <= op_a;
      b_q[1] <= op_b;
    end
    if (vld[1]) begin
      a_q[2] <= a_q[1];
      b_q[2] <= b_q[1];
    end
  end

  always_ff @(posedge clk) begin
    if (vld[MUL_STAGE-1]) prod_q[MUL_STAGE] <= prod_d;
    for (int k = MUL_STAGE + 1; k <= FWD_STAGE; k++) begin
      if (vld[k-1]) prod_q[k] <= prod_q[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (vld[ACC_RD_STAGE]) acc_q[ACC_RD_STAGE+1] <= acc_d;
    for (int k = ACC_RD_STAGE + 2; k <= FWD_STAGE; k++) begin
      if (vld[k-1]) acc_q[k] <= acc_q[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (vld[FWD_STAGE]) sum_q[FWD_STAGE+1] <= sum_d;
    for (int k = FWD_STAGE + 2; k <= STAGES; k++) begin
      if (vld[k-1]) sum_q[k] <= sum_q[k-1];
    end
  end

  assign sum_out = sum_q[STAGES];
endmodule

// File: rtl/mac2_pipe.sv
module mac2_pipe
  import mac2_pkg::*;
#(
  parameter int LANES = 2,
  parameter int EW    = 32,
  parameter int DST_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    issue_valid,
  output logic                    issue_ready,
  input  logic                    issue_op,
  input  logic [DST_W-1:0]        issue_dst,
  input  logic [LANES*EW-1:0]     issue_a,
  input  logic [LANES*EW-1:0]     issue_b,
  output logic                    acc_rd_en,
  output logic [DST_W-1:0]        acc_rd_dst,
  input  logic [LANES*2*EW-1:0]   acc_rd_data,
  output logic                    res_valid,
  output logic [DST_W-1:0]        res_dst,
  output logic [LANES*2*EW-1:0]   res_data
);
  localparam int PW = 2 * EW;

  typedef struct packed {
    logic             mac;
    logic             chain;
    logic [DST_W-1:0] dst;
  } pay_t;

  logic [STAGES:1] vld_q, vld_d;
  pay_t            pay_q [1:STAGES];
  pay_t            pay_d [1:STAGES];

  logic                         take, take_chain;
  logic [HAZ_LAST:1]            haz_vld;
  logic [HAZ_LAST:1][DST_W-1:0] haz_dst;
  logic                         fwd_take;

  always_comb begin
    for (int k = 1; k <= HAZ_LAST; k++) begin
      haz_vld[k] = vld_q[k];
      haz_dst[k] = pay_q[k].dst;
    end
  end

  mac2_issue_ctl #(.DST_W(DST_W)) u_issue (
    .issue_valid (issue_valid),
    .issue_op    (issue_op),
    .issue_dst   (issue_dst),
    .stg_vld     (haz_vld),
    .stg_dst     (haz_dst),
    .issue_ready (issue_ready),
    .take        (take),
    .take_chain  (take_chain)
  );

  // next-state of the control pipe
  always_comb begin
    vld_d[1]       = take;
    pay_d[1].mac   = (issue_op == OP_MAC);
    pay_d[1].chain = take_chain;
    pay_d[1].dst   = issue_dst;
    for (int k = 2; k <= STAGES; k++) begin
      vld_d[k] = vld_q[k-1];
      pay_d[k] = pay_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    for (int k = 1; k <= STAGES; k++) begin
      if (vld_d[k]) pay_q[k] <= pay_d[k];
    end
  end

  assign acc_rd_en  = vld_q[ACC_RD_STAGE] && pay_q[ACC_RD_STAGE].mac &&
                      !pay_q[ACC_RD_STAGE].chain;
  assign acc_rd_dst = pay_q[ACC_RD_STAGE].dst;
  assign fwd_take   = vld_q[FWD_STAGE] && pay_q[FWD_STAGE].chain;
  assign res_valid  = vld_q[STAGES];
  assign res_dst    = pay_q[STAGES].dst;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    mac2_lane #(.EW(EW)) u_lane (
      .clk      (clk),
      .take     (take),
      .vld      (vld_q[STAGES-1:1]),
      .op_a     (issue_a[l*EW +: EW]),
      .op_b     (issue_b[l*EW +: EW]),
      .acc_take (acc_rd_en),
      .acc_in   (acc_rd_data[l*PW +: PW]),
      .fwd_take (fwd_take),
      .sum_out  (res_data[l*PW +: PW])
    );
  end
endmodule

// File: rtl/mac2_pipe_chk.sv
module mac2_pipe_chk #(
  parameter int DST_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issue_valid,
  input logic             issue_ready,
  input logic             issue_op,
  input logic [DST_W-1:0] issue_dst,
  input logic             acc_rd_en,
  input logic [DST_W-1:0] acc_rd_dst,
  input logic             res_valid,
  input logic [DST_W-1:0] res_dst
);
  logic take;
  assign take = issue_valid && issue_ready;

  assert_issue_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !issue_ready);

  assert_result_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(take, 8));

  assert_acc_read_time_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd_en |-> $past(take && issue_op, 3));

  assert_chain_no_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && issue_op && $past(take, 2) && ($past(issue_dst, 2) == issue_dst))
      |=> ##2 !acc_rd_en);

  assert_no_pending_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd_en && res_valid) |-> (acc_rd_dst != res_dst));

  assert_outputs_known_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(res_valid) && !$isunknown(acc_rd_en) && !$isunknown(issue_ready));

  assert_mul_no_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !issue_op) |=> ##2 !acc_rd_en);
endmodule

bind mac2_pipe mac2_pipe_chk #(.DST_W(DST_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .issue_valid (issue_valid),
  .issue_ready (issue_ready),
  .issue_op    (issue_op),
  .issue_dst   (issue_dst),
  .acc_rd_en   (acc_rd_en),
  .acc_rd_dst  (acc_rd_dst),
  .res_valid   (res_valid),
  .res_dst     (res_dst)
);

// File: tb/test_mac2_pipe.sv
`timescale 1ns/1ps
module test_mac2_pipe;
  localparam int LANES = 2;
  localparam int EW    = 32;
  localparam int DST_W = 4;
  localparam int AW    = LANES * EW;
  localparam int RW    = LANES * 2 * EW;
  localparam int NDST  = 1 << DST_W;

  logic clk, rst_n;
  logic issue_valid, issue_ready, issue_op;
  logic [DST_W-1:0] issue_dst, acc_rd_dst, res_dst;
  logic [AW-1:0] issue_a, issue_b;
  logic acc_rd_en, res_valid;
  logic [RW-1:0] acc_rd_data, res_data;

  mac2_pipe #(.LANES(LANES), .EW(EW), .DST_W(DST_W)) i_mac2_pipe (
    .clk(clk), .rst_n(rst_n),
    .issue_valid(issue_valid), .issue_ready(issue_ready), .issue_op(issue_op),
    .issue_dst(issue_dst), .issue_a(issue_a), .issue_b(issue_b),
    .acc_rd_en(acc_rd_en), .acc_rd_dst(acc_rd_dst), .acc_rd_data(acc_rd_data),
    .res_valid(res_valid), .res_dst(res_dst), .res_data(res_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [RW-1:0] init_val(input int i);
    return {64'(i) * 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFF0_0000_0000 ^ 64'(i * 7 + 1)};
  endfunction

  // external register file: written when the result leaves, read same cycle
  logic [RW-1:0] rf [NDST];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NDST; i++) rf[i] <= init_val(i);
    end else if (res_valid) begin
      rf[res_dst] <= res_data;
    end
  end
  assign acc_rd_data = rf[acc_rd_dst];

  // reference model
  logic [RW-1:0]    arch [NDST];
  int               step;
  int               res_due[$];
  logic [DST_W-1:0] res_dq[$];
  logic [RW-1:0]    res_xq[$];
  string            res_tag[$];
  int               rd_due[$];
  logic [DST_W-1:0] rd_dq[$];
  int               hist_step[$];
  logic [DST_W-1:0] hist_dst[$];
  int checks, errors;
  bit done;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [RW-1:0] act, input logic [RW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h (step %0d)", tag, what, act, exp, step);
    end
  endtask

  task automatic check_outputs();
    bit ev, er;
    string t;
    ev = (res_due.size() > 0) && (res_due[0] <= step);
    t  = ev ? res_tag[0] : "R3";
    check(res_valid == ev, t, "res_valid", RW'(res_valid), RW'(ev));
    if (ev && res_valid) begin
      check(res_dst == res_dq[0], t, "res_dst", RW'(res_dst), RW'(res_dq[0]));
      check(res_data == res_xq[0], t, "res_data", res_data, res_xq[0]);
    end
    if (ev) begin
      void'(res_due.pop_front()); void'(res_dq.pop_front());
      void'(res_xq.pop_front());  void'(res_tag.pop_front());
    end
    er = (rd_due.size() > 0) && (rd_due[0] <= step);
    check(acc_rd_en == er, "R4", "acc_rd_en", RW'(acc_rd_en), RW'(er));
    if (er && acc_rd_en)
      check(acc_rd_dst == rd_dq[0], "R4", "acc_rd_dst", RW'(acc_rd_dst), RW'(rd_dq[0]));
    if (er) begin
      void'(rd_due.pop_front()); void'(rd_dq.pop_front());
    end
  endtask

  task automatic model_ready(input bit op, input logic [DST_W-1:0] dst,
                             output bit ready, output bit chain, output string why);
    bit busy, haz;
    int n;
    n     = hist_step.size();
    busy  = (n > 0) && (hist_step[n-1] == step - 1);
    chain = op && (n > 0) && (hist_step[n-1] == step - 2) && (hist_dst[n-1] == dst);
    haz   = 1'b0;
    for (int i = 0; i < n; i++) begin
      int g;
      g = step - hist_step[i];
      if (g >= 1 && g <= 5 && hist_dst[i] == dst) haz = 1'b1;
    end
    ready = !busy && !(op && haz && !chain);
    why   = busy ? "R2" : (op && haz && !chain) ? "R7" : chain ? "R5" : "R9";
  endtask

  task automatic push_model(input bit op, input logic [DST_W-1:0] dst,
                            input logic [AW-1:0] a, input logic [AW-1:0] b,
                            input bit chain, input string tag);
    logic [RW-1:0] r;
    for (int l = 0; l < LANES; l++) begin
      logic signed [EW-1:0] x, y;
      longint p;
      x = a[l*EW +: EW];
      y = b[l*EW +: EW];
      p = longint'(x) * longint'(y);
      r[l*2*EW +: 2*EW] = 64'(p) + (op ? arch[dst][l*2*EW +: 2*EW] : 64'd0);
    end
    arch[dst] = r;
    res_due.push_back(step + 8); res_dq.push_back(dst);
    res_xq.push_back(r);         res_tag.push_back(tag);
    if (op && !chain) begin
      rd_due.push_back(step + 3); rd_dq.push_back(dst);
    end
    hist_step.push_back(step); hist_dst.push_back(dst);
    while (hist_step.size() > 8) begin
      void'(hist_step.pop_front()); void'(hist_dst.pop_front());
    end
  endtask

  task automatic cycle(input bit v, input bit op, input logic [DST_W-1:0] dst,
                       input logic [AW-1:0] a, input logic [AW-1:0] b,
                       input string tag, output bit took);
    bit r, ch;
    string why;
    @(negedge clk);
    check_outputs();
    issue_valid = v; issue_op = op; issue_dst = dst; issue_a = a; issue_b = b;
    #1;
    model_ready(op, dst, r, ch, why);
    check(issue_ready == r, why, "issue_ready", RW'(issue_ready), RW'(r));
    took = v && r;
    if (took) push_model(op, dst, a, b, ch, tag);
    step++;
  endtask

  task automatic issue(input bit op, input logic [DST_W-1:0] dst,
                       input logic [AW-1:0] a, input logic [AW-1:0] b, input string tag);
    bit took;
    do cycle(1'b1, op, dst, a, b, tag, took); while (!took);
  endtask

  task automatic idle(input int n);
    bit took;
    for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, '0, '0, '0, "R9", took);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0; step = 0;
    for (int i = 0; i < NDST; i++) arch[i] = init_val(i);
    rst_n = 1'b0; issue_valid = 1'b0; issue_op = 1'b0;
    issue_dst = '0; issue_a = '0; issue_b = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(res_valid == 1'b0, "R9", "res_valid in reset", RW'(res_valid), '0);
    check(acc_rd_en == 1'b0, "R9", "acc_rd_en in reset", RW'(acc_rd_en), '0);
    check(issue_ready == 1'b1, "R9", "issue_ready in reset", RW'(issue_ready), RW'(1));
    rst_n = 1'b1;
    idle(2);

    // R1: signed products in both lanes
    issue(1'b0, 4'd1, {32'd7, 32'hFFFF_FFFD}, {32'hFFFF_FFF7, 32'd5}, "R1");
    issue(1'b0, 4'd2, {32'h8000_0000, 32'h8000_0000}, {32'h7FFF_FFFF, 32'h8000_0000}, "R3");
    idle(10);
    // R4: accumulate from the register port
    issue(1'b1, 4'd3, {32'hFFFF_0001, 32'd100}, {32'd3, 32'hFFFF_FFFF}, "R4");
    idle(10);
    // R5, R6: dependent chain at full rate
    issue(1'b0, 4'd5, {32'd11, 32'd2}, {32'd13, 32'd3}, "R1");
    issue(1'b1, 4'd5, {32'hFFFF_FFFE, 32'd4}, {32'd6, 32'd5}, "R5");
    issue(1'b1, 4'd5, {32'd9, 32'hFFFF_FF00}, {32'd9, 32'd7}, "R6");
    idle(12);
    // R7: producer two instructions back must stall the accumulate
    issue(1'b0, 4'd7, {32'd21, 32'd17}, {32'd2, 32'd3}, "R1");
    issue(1'b0, 4'd8, {32'd1, 32'd1}, {32'd1, 32'd1}, "R1");
    issue(1'b1, 4'd7, {32'd5, 32'd5}, {32'd5, 32'd5}, "R7");
    idle(12);
    // R8: wrap across 2^63 in both lanes
    issue(1'b0, 4'd9, {32'h7FFF_FFFF, 32'h8000_0000}, {32'h7FFF_FFFF, 32'h8000_0000}, "R8");
    issue(1'b1, 4'd9, {32'h7FFF_FFFF, 32'h8000_0000}, {32'h7FFF_FFFF, 32'h8000_0000}, "R8");
    issue(1'b1, 4'd9, {32'h7FFF_FFFF, 32'h8000_0000}, {32'h7FFF_FFFF, 32'h8000_0000}, "R8");
    idle(12);
    // R10: plain multiply ignores the nonzero register contents
    issue(1'b0, 4'd10, {32'd3, 32'hFFFF_FFFF}, {32'd3, 32'd1}, "R10");
    idle(10);
    // R2: valid held every cycle
    for (int i = 0; i < 6; i++) issue(1'b0, 4'(11 + i % 4), AW'(i + 1), AW'(i + 2), "R2");
    idle(10);
    // mixed stream on a few destinations
    for (int i = 0; i < 400; i++) begin
      bit took, v, op;
      v  = ($urandom % 10) < 7;
      op = $urandom % 2;
      cycle(v, op, 4'($urandom % 4), {$urandom, $urandom}, {$urandom, $urandom},
            op ? "R4" : "R1", took);
    end
    idle(12);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule